// File: doc/BRIEF.md
# UTLB Address-Array Write Unit

This block owns the tag half of a 64-entry unified translation buffer and a four-entry instruction translation buffer. It sits behind a 128 MB memory-mapped control window and takes 32-bit bus writes. Address bits 26:24 of each write choose one of eight array targets. Only the unified-buffer address array is acted on. Cache-array targets are dropped silently, and unimplemented targets raise a one-cycle error strobe.

A write to the address array runs in one of two modes.

- **Indexed write** (address bit 7 clear): replaces one whole entry in a single cycle.
- **Associative write** (address bit 7 set): scans every entry for a matching page number and address-space identifier, one entry per clock. It updates the valid and dirty bits of each hit. It then updates the instruction buffer to match the result.

A second hit during the scan raises a multiple-hit exception. Entries that lose their valid bit produce a page-invalidate request toward the translation cache. The unit also advances the replacement counter held in the MMU control register.

The control sequencer has three states:

- **IDLE**: accepts writes.
  - Transition *IDLE→SCAN*: taken on an associative write.
  - An indexed write, an ignored write or a rejected write completes in IDLE.
- **SCAN**: examines one unified entry per cycle.
  - Transition *SCAN→SYNC*: taken after the last entry, or on a second hit.
- **SYNC**: updates the instruction buffer and issues a pending invalidate.
  - Transition *SYNC→IDLE*: unconditional.

Top module: `mmu_utlb_aa_writer`

## Requirements
- R1: The window is addresses 0xF0000000–0xF7FFFFFF, and bits 26:24 select the target: 0 and 1 are instruction-cache address/data, 2 and 3 are instruction-buffer address/data, 4 and 5 are operand-cache address/data, 6 is the unified address array, and 7 is the unified data array. Writes to targets 0, 1, 4 and 5 change no state and raise no error.
- R2: A write to target 2, 3 or 7, or to any address outside the window, raises `bad_access` for exactly one cycle, in the cycle after the write is accepted. It changes no other state.
- R3: Write data splits into a page number (bits 31:10), a dirty bit (bit 9), a valid bit (bit 8) and an ASID (bits 7:0). With address bit 7 clear, the unified entry chosen by address bits 13:8 is fully overwritten. The replacement counter steps once.
- R4: Before an indexed overwrite, if the old entry was valid and no instruction-buffer entry is identical to it in all four fields, `inval_valid` pulses with `inval_addr` = old page number << 10.
- R5: With address bit 7 set, every valid unified entry whose page number and ASID both match the write data receives the written valid and dirty bits.
- R6: A second matching entry during the scan does the following:
  - It raises `exc_valid` for one cycle with `exc_code` = 0x140.
  - It latches the write address into `fault_addr`.
  - It ends the scan. That entry and all later entries are left untouched.
- R7: After the scan, the first instruction-buffer entry whose page number and ASID match the write is updated. If a unified entry matched, that whole updated entry is copied in. Otherwise only the entry's valid bit takes the written value. The instruction buffer resets to all zeros.
- R8: During an associative write, if any matched unified or instruction-buffer entry goes from valid to invalid, `inval_valid` pulses once after the scan, with `inval_addr` = written page number << 10.
- R9: The replacement counter occupies MMU control register bits 15:10, and its boundary occupies bits 23:18.
  - A step adds one to the counter. The result becomes 0 when it equals the boundary or equals 63.
  - A step leaves all other register bits unchanged.
  - `ctl_we` loads the whole register and takes priority over a step.
- R10: During an associative scan, the counter steps once for each valid unified entry examined. The entry that triggers the multiple-hit exception is not counted.
- R11: An associative write keeps `busy` high for 65 cycles: 64 scan cycles plus one update cycle. Bus writes presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 32 | Bus write address |
| bus_wdata | input | 32 | Bus write data |
| busy | output | 1 | Associative write in progress; writes ignored |
| bad_access | output | 1 | One-cycle error for unimplemented targets |
| ctl_we | input | 1 | Load strobe for the MMU control register |
| ctl_wdata | input | 32 | MMU control register load value |
| mmucr | output | 32 | MMU control register contents |
| exc_valid | output | 1 | Multiple-hit exception pulse |
| exc_code | output | 12 | Exception code (0x140) |
| fault_addr | output | 32 | Address of the write that caused the exception |
| inval_valid | output | 1 | Page-invalidate request pulse |
| inval_addr | output | 32 | Page address to invalidate |

## Verification
The write path is tried with five kinds of input pattern:

- Indexed writes to fresh entries, which separate field extraction from index decoding.
- Overwrites of valid entries, both with and without an identical instruction-buffer copy, which show whether the invalidate suppression compares all four fields.
- Associative writes with zero, one and two hits, which distinguish updating one hit, stopping at the second hit, and the instruction-buffer fallback that only sets the valid bit.
- Cache-target, unimplemented-target and out-of-window addresses, which show that ignoring a write differs from rejecting it.
- Long runs of indexed writes under different boundary values, which tell the boundary wrap apart from the fixed wrap at 63.

// File: rtl/mmu_tag_pkg.sv
package mmu_tag_pkg;

    localparam int VPN_W    = 22;
    localparam int ASID_W   = 8;
    localparam int CNT_W    = 6;
    localparam int URC_LSB  = 10;
    localparam int URB_LSB  = 18;
    localparam logic [11:0] MULTI_HIT_CODE = 12'h140;

    // Field order mirrors the bus data word: page[31:10] d[9] v[8] asid[7:0]
    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic              dirty;
        logic              valid;
        logic [ASID_W-1:0] asid;
    } tag_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_SYNC
    } wr_state_e;

    typedef enum logic [2:0] {
        RG_IC_ADDR   = 3'd0,
        RG_IC_DATA   = 3'd1,
        RG_IT_ADDR   = 3'd2,
        RG_IT_DATA   = 3'd3,
        RG_OC_ADDR   = 3'd4,
        RG_OC_DATA   = 3'd5,
        RG_UT_ADDR   = 3'd6,
        RG_UT_DATA   = 3'd7
    } region_e;

    typedef enum logic [1:0] {
        TGT_IGNORE,
        TGT_UTLB_TAG,
        TGT_REJECT
    } target_e;

endpackage

// File: rtl/mmu_win_decode.sv
module mmu_win_decode
    import mmu_tag_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'hF000_0000,
    parameter int          WIN_AW   = 27,
    parameter int          IDX_W    = 6
) (
    input  logic [31:WIN_AW-3] win_bits,
    input  logic               mode_bit,
    input  logic [IDX_W-1:0]   idx_bits,
    output target_e            target,
    output logic               assoc,
    output logic [IDX_W-1:0]   index
);
    localparam int REG_LSB = WIN_AW - 3;

    logic    in_window;
    region_e region;

    assign in_window = (win_bits[31:WIN_AW] == WIN_BASE[31:WIN_AW]);
    assign region    = region_e'(win_bits[WIN_AW-1:REG_LSB]);
    assign assoc     = mode_bit;
    assign index     = idx_bits;

    always_comb begin
        if (!in_window) begin
            target = TGT_REJECT;
        end else begin
            unique case (region)
                RG_UT_ADDR:                         target = TGT_UTLB_TAG;
                RG_IT_ADDR, RG_IT_DATA, RG_UT_DATA: target = TGT_REJECT;
                default:                            target = TGT_IGNORE;
            endcase
        end
    end

endmodule

// File: rtl/mmu_ctrl_reg.sv
module mmu_ctrl_reg
    import mmu_tag_pkg::*;
#(
    parameter int URC_LIMIT = 63
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_we,
    input  logic [31:0] sw_data,
    input  logic        step,
    output logic [31:0] value
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(URC_LIMIT);

    logic [CNT_W-1:0] urc_cur;
    logic [CNT_W-1:0] urb_cur;
    logic [CNT_W-1:0] urc_nxt;

    assign urc_cur = value[URC_LSB +: CNT_W];
    assign urb_cur = value[URB_LSB +: CNT_W];

    always_comb begin
        urc_nxt = urc_cur + 1'b1;
        if (urc_nxt == urb_cur || urc_nxt == LIMIT) begin
            urc_nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (sw_we) begin
            value <= sw_data;
        end else if (step) begin
            value[URC_LSB +: CNT_W] <= urc_nxt;
        end
    end

endmodule

// File: rtl/mmu_itlb_store.sv
module mmu_itlb_store
    import mmu_tag_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  key_vpn,
    input  logic [ASID_W-1:0] key_asid,
    input  tag_t              probe,
    input  logic              upd_en,
    input  logic              upd_copy,
    input  tag_t              upd_src,
    input  logic              upd_valid,
    output logic              hit,
    output logic              hit_valid,
    output logic              dup_exists
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    tag_t             ent [DEPTH];
    logic [DEPTH-1:0] key_eq;
    logic [DEPTH-1:0] same;
    logic [IW-1:0]    hit_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign key_eq[g] = (ent[g].vpn == key_vpn) && (ent[g].asid == key_asid);
        assign same[g]   = (ent[g] == probe);
    end

    assign dup_exists = |same;

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (!hit && key_eq[j]) begin
                hit     = 1'b1;
                hit_idx = IW'(j);
            end
        end
    end

    assign hit_valid = ent[hit_idx].valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) begin
                ent[j] <= '0;
            end
        end else if (upd_en && hit) begin
            if (upd_copy) begin
                ent[hit_idx] <= upd_src;
            end else begin
                ent[hit_idx].valid <= upd_valid;
            end
        end
    end

endmodule

// File: rtl/mmu_utlb_aa_writer.sv
module mmu_utlb_aa_writer
    import mmu_tag_pkg::*;
#(
    parameter int          UTLB_DEPTH = 64,
    parameter int          ITLB_DEPTH = 4,
    parameter logic [31:0] WIN_BASE   = 32'hF000_0000,
    parameter int          WIN_AW     = 27
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic        busy,
    output logic        bad_access,
    input  logic        ctl_we,
    input  logic [31:0] ctl_wdata,
    output logic [31:0] mmucr,
    output logic        exc_valid,
    output logic [11:0] exc_code,
    output logic [31:0] fault_addr,
    output logic        inval_valid,
    output logic [31:0] inval_addr
);
    localparam int            UIDX_W = $clog2(UTLB_DEPTH);
    localparam logic [UIDX_W-1:0] LAST_IDX = UIDX_W'(UTLB_DEPTH - 1);
    localparam int            PAGE_SH = 32 - VPN_W;

    wr_state_e         state, state_nxt;
    tag_t              utlb [UTLB_DEPTH];
    tag_t              pend;
    logic [31:0]       req_addr;
    logic [UIDX_W-1:0] scan_idx;
    logic [UIDX_W-1:0] hit_idx;
    logic              hit_found;
    logic              flush_pend;

    target_e           target;
    logic              assoc;
    logic [UIDX_W-1:0] dec_idx;
    logic              accept;
    logic              tag_write;

    tag_t              cur;
    logic              cur_match;
    logic              second_hit;
    logic              urc_step;

    logic              it_hit;
    logic              it_hit_valid;
    logic              it_dup;
    logic              sync_flush;

    mmu_win_decode #(
        .WIN_BASE (WIN_BASE),
        .WIN_AW   (WIN_AW),
        .IDX_W    (UIDX_W)
    ) i_decode (
        .win_bits (bus_addr[31:WIN_AW-3]),
        .mode_bit (bus_addr[7]),
        .idx_bits (bus_addr[8 +: UIDX_W]),
        .target   (target),
        .assoc    (assoc),
        .index    (dec_idx)
    );

    assign accept    = bus_we && (state == ST_IDLE);
    assign tag_write = accept && (target == TGT_UTLB_TAG);

    assign cur        = utlb[scan_idx];
    assign cur_match  = cur.valid && (cur.vpn == pend.vpn) && (cur.asid == pend.asid);
    assign second_hit = cur_match && hit_found;

    assign urc_step = (tag_write && !assoc) ||
                      ((state == ST_SCAN) && cur.valid && !second_hit);

    mmu_ctrl_reg #(
        .URC_LIMIT (UTLB_DEPTH - 1)
    ) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_we   (ctl_we),
        .sw_data (ctl_wdata),
        .step    (urc_step),
        .value   (mmucr)
    );

    mmu_itlb_store #(
        .DEPTH (ITLB_DEPTH)
    ) i_itlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_vpn    (pend.vpn),
        .key_asid   (pend.asid),
        .probe      (utlb[dec_idx]),
        .upd_en     (state == ST_SYNC),
        .upd_copy   (hit_found),
        .upd_src    (utlb[hit_idx]),
        .upd_valid  (pend.valid),
        .hit        (it_hit),
        .hit_valid  (it_hit_valid),
        .dup_exists (it_dup)
    );

    assign sync_flush = flush_pend || (it_hit && it_hit_valid && !pend.valid);
    assign busy       = (state != ST_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (tag_write && assoc) state_nxt = ST_SCAN;
            ST_SCAN: if (second_hit || scan_idx == LAST_IDX) state_nxt = ST_SYNC;
            ST_SYNC: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Outputs and array updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < UTLB_DEPTH; i++) begin
                utlb[i] <= '0;
            end
            pend        <= '0;
            req_addr    <= '0;
            scan_idx    <= '0;
            hit_idx     <= '0;
            hit_found   <= 1'b0;
            flush_pend  <= 1'b0;
            bad_access  <= 1'b0;
            exc_valid   <= 1'b0;
            exc_code    <= '0;
            fault_addr  <= '0;
            inval_valid <= 1'b0;
            inval_addr  <= '0;
        end else begin
            bad_access  <= 1'b0;
            exc_valid   <= 1'b0;
            inval_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept && target == TGT_REJECT) begin
                        bad_access <= 1'b1;
                    end
                    if (tag_write) begin
                        if (assoc) begin
                            pend       <= tag_t'(bus_wdata);
                            req_addr   <= bus_addr;
                            scan_idx   <= '0;
                            hit_found  <= 1'b0;
                            flush_pend <= 1'b0;
                        end else begin
                            if (utlb[dec_idx].valid && !it_dup) begin
                                inval_valid <= 1'b1;
                                inval_addr  <= {utlb[dec_idx].vpn, PAGE_SH'(0)};
                            end
                            utlb[dec_idx] <= tag_t'(bus_wdata);
                        end
                    end
                end
                ST_SCAN: begin
                    if (second_hit) begin
                        exc_valid  <= 1'b1;
                        exc_code   <= MULTI_HIT_CODE;
                        fault_addr <= req_addr;
                    end else if (cur_match) begin
                        utlb[scan_idx].valid <= pend.valid;
                        utlb[scan_idx].dirty <= pend.dirty;
                        hit_found            <= 1'b1;
                        hit_idx              <= scan_idx;
                        if (!pend.valid) begin
                            flush_pend <= 1'b1;
                        end
                    end
                    scan_idx <= scan_idx + 1'b1;
                end
                ST_SYNC: begin
                    if (sync_flush) begin
                        inval_valid <= 1'b1;
                        inval_addr  <= {pend.vpn, PAGE_SH'(0)};
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mmu_utlb_aa_writer_chk.sv
module mmu_utlb_aa_writer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        busy,
    input logic        bad_access,
    input logic        ctl_we,
    input logic [31:0] ctl_wdata,
    input logic [31:0] mmucr,
    input logic        exc_valid,
    input logic [11:0] exc_code,
    input logic [31:0] fault_addr,
    input logic        inval_valid,
    input logic [31:0] inval_addr
);
    // R2: an error follows an accepted write in the idle state
    a_r2_err_after_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> ($past(bus_we) && !$past(busy)));

    // R11: writes presented while busy leave no error behind
    a_r11_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_we) |=> !bad_access);

    // R6: the exception carries the multiple-hit code
    a_r6_exc_code: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_code == 12'h140));

    // R6: the fault address only moves with an exception
    a_r6_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |-> $stable(fault_addr));

    // R6: exceptions arise only during a scan
    a_r6_exc_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> $past(busy));

    // R8: invalidate requests are page aligned
    a_r8_inval_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        inval_valid |-> (inval_addr[9:0] == 10'd0));

    // R9: without a load, only the counter field may change
    a_r9_other_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> ({mmucr[31:16], mmucr[9:0]} == {$past(mmucr[31:16]), $past(mmucr[9:0])}));

endmodule

bind mmu_utlb_aa_writer mmu_utlb_aa_writer_chk i_chk (.*);

// File: tb/test_mmu_utlb_aa_writer.sv
module test_mmu_utlb_aa_writer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        busy;
    logic        bad_access;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] mmucr;
    logic        exc_valid;
    logic [11:0] exc_code;
    logic [31:0] fault_addr;
    logic        inval_valid;
    logic [31:0] inval_addr;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    // pulse monitors
    int          err_cnt, inv_cnt, exc_cnt;
    logic [31:0] inv_last;

    // reference state, entries stored in the bus data layout
    logic [31:0] m_u [64];
    logic [31:0] m_i [4];
    logic [31:0] m_cr;

    always #5 clk = ~clk;

    mmu_utlb_aa_writer i_mmu_utlb_aa_writer (
        .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .busy, .bad_access,
        .ctl_we, .ctl_wdata, .mmucr, .exc_valid, .exc_code, .fault_addr,
        .inval_valid, .inval_addr
    );

    always @(negedge clk) begin
        if (bad_access) err_cnt++;
        if (exc_valid) exc_cnt++;
        if (inval_valid) begin
            inv_cnt++;
            inv_last = inval_addr;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic m_step();
        logic [5:0] c;
        c = m_cr[15:10] + 6'd1;
        if (c == m_cr[23:18] || c == 6'd63) c = 6'd0;
        m_cr[15:10] = c;
    endtask

    // Reference behaviour of one bus write
    task automatic model(input logic [31:0] a, input logic [31:0] d,
                         output int e_err, output int e_inv, output logic [31:0] e_ia,
                         output int e_exc);
        e_err = 0; e_inv = 0; e_ia = '0; e_exc = 0;
        if (a[31:27] != 5'b11110 || a[26:24] == 3'd2 || a[26:24] == 3'd3 || a[26:24] == 3'd7) begin
            e_err = 1;
        end else if (a[26:24] == 3'd6) begin
            if (!a[7]) begin
                logic [31:0] old;
                bit same;
                old = m_u[a[13:8]];
                same = 0;
                for (int j = 0; j < 4; j++) if (m_i[j] == old) same = 1;
                if (old[8] && !same) begin
                    e_inv = 1;
                    e_ia = {old[31:10], 10'd0};
                end
                m_u[a[13:8]] = d;
                m_step();
            end else begin
                int found;
                bit flush;
                found = -1;
                flush = 0;
                for (int i = 0; i < 64; i++) begin
                    if (!m_u[i][8]) continue;
                    if (m_u[i][31:10] == d[31:10] && m_u[i][7:0] == d[7:0]) begin
                        if (found >= 0) begin
                            e_exc = 1;
                            break;
                        end
                        if (!d[8]) flush = 1;
                        m_u[i][9] = d[9];
                        m_u[i][8] = d[8];
                        found = i;
                    end
                    m_step();
                end
                for (int j = 0; j < 4; j++) begin
                    if (m_i[j][31:10] == d[31:10] && m_i[j][7:0] == d[7:0]) begin
                        if (m_i[j][8] && !d[8]) flush = 1;
                        if (found >= 0) m_i[j] = m_u[found];
                        else m_i[j][8] = d[8];
                        break;
                    end
                end
                if (flush) begin
                    e_inv = 1;
                    e_ia = {d[31:10], 10'd0};
                end
            end
        end
    endtask

    function automatic string tag_of(input logic [31:0] a);
        if (a[31:27] != 5'b11110) return "R2";
        case (a[26:24])
            3'd6: return a[7] ? "R5/R7/R8" : "R3/R4";
            3'd2, 3'd3, 3'd7: return "R2";
            default: return "R1";
        endcase
    endfunction

    task automatic do_write(input logic [31:0] a, input logic [31:0] d);
        int e_err, e_inv, e_exc;
        logic [31:0] e_ia;
        string t;
        t = tag_of(a);
        model(a, d, e_err, e_inv, e_ia, e_exc);
        err_cnt = 0; inv_cnt = 0; exc_cnt = 0;
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check({t, " error strobe"}, err_cnt, e_err);
        check({t, " invalidate count"}, inv_cnt, e_inv);
        if (e_inv != 0 && inv_cnt == e_inv) check({t, " invalidate address"}, inv_last, e_ia);
        check("R6 exception count", exc_cnt, e_exc);
        if (e_exc != 0) check("R6 fault address", fault_addr, a);
        check("R10 control register", mmucr, m_cr);
    endtask

    task automatic do_ctl(input logic [31:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
        m_cr = v;
        check("R9 control load", mmucr, v);
    endtask

    // {address, data}
    localparam logic [63:0] VEC [17] = '{
        {32'hF600_0300, 32'h1234_5B05},  // R3 indexed, fresh entry
        {32'hF600_0500, 32'hABCD_0122},
        {32'hF600_0300, 32'h0000_4100},  // R4 overwrite of a valid entry
        {32'hF000_0300, 32'hFFFF_FFFF},  // R1 cache target ignored
        {32'hF100_0000, 32'hFFFF_FFFF},
        {32'hF400_0000, 32'hFFFF_FFFF},
        {32'hF500_0000, 32'hFFFF_FFFF},
        {32'hF200_0000, 32'h0000_0100},  // R2 rejected targets
        {32'hF300_0000, 32'h0000_0100},
        {32'hF700_0000, 32'h0000_0100},
        {32'hE000_0000, 32'h0000_0100},
        {32'hF600_3F00, 32'hFFFF_FD7F},  // R3 last index
        {32'hF600_0A00, 32'h0000_0100},
        {32'hF600_0080, 32'h0000_0300},  // R5/R7 one hit, copy into instruction buffer
        {32'hF600_0A00, 32'h0000_8100},  // R4 identical copy suppresses invalidate
        {32'hF600_0080, 32'hABCD_0022},  // R8 valid to invalid
        {32'hF600_0080, 32'h0000_0100}   // R7 no unified hit, valid bit only
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) m_u[i] = '0;
        for (int j = 0; j < 4; j++) m_i[j] = '0;
        m_cr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R9 reset control register", mmucr, 32'h0);
        check("R11 reset busy", {31'd0, busy}, 32'd0);
        check("R2 reset error", {31'd0, bad_access}, 32'd0);
        check("R6 reset fault address", fault_addr, 32'h0);
        check("R8 reset invalidate", {31'd0, inval_valid}, 32'd0);

        for (int k = 0; k < 17; k++) do_write(VEC[k][63:32], VEC[k][31:0]);

        // R7 instruction buffer valid 1->0 without a unified hit gives an invalidate at page 0
        do_write(32'hF600_0080, 32'h0000_0000);
        check("R7 invalidate from instruction buffer", inv_cnt, 1);

        // R6 multiple hit
        do_write(32'hF600_1400, 32'h5555_5566);
        do_write(32'hF600_1500, 32'h5555_5566);
        do_write(32'hF600_0080, 32'h5555_5466);
        check("R6 exception code", {20'd0, exc_code}, 32'h140);
        check("R6 exception raised", exc_cnt, 1);
        // R6 second entry was left valid: a repeat now hits it alone
        do_write(32'hF600_0080, 32'h5555_5466);
        check("R6 untouched entry still matches", inv_cnt, 1);
        check("R6 no exception on single hit", exc_cnt, 0);

        // R9 boundary wrap, other bits preserved
        do_ctl(32'h8000_0005 | (32'd3 << 18));
        do_write(32'hF600_2800, 32'h0000_0000);
        check("R9 step to 1", mmucr, 32'h800C_0405);
        do_write(32'hF600_2800, 32'h0000_0000);
        check("R9 step to 2", mmucr, 32'h800C_0805);
        do_write(32'hF600_2800, 32'h0000_0000);
        check("R9 wrap at boundary", mmucr, 32'h800C_0005);

        // R9 fixed wrap at 63 with boundary 0
        do_ctl(32'h0);
        for (int k = 0; k < 62; k++) do_write(32'hF600_2800, 32'h0000_0000);
        check("R9 counter reaches 62", mmucr, 32'd62 << 10);
        do_write(32'hF600_2800, 32'h0000_0000);
        check("R9 wrap at 63", mmucr, 32'h0);

        // R11 busy length and hold-off
        begin
            int e_err, e_inv, e_exc, cyc;
            logic [31:0] e_ia;
            model(32'hF600_0080, 32'h7777_7700, e_err, e_inv, e_ia, e_exc);
            err_cnt = 0; inv_cnt = 0; exc_cnt = 0;
            cyc = 0;
            @(negedge clk);
            bus_we = 1'b1; bus_addr = 32'hF600_0080; bus_wdata = 32'h7777_7700;
            @(negedge clk);
            bus_we = 1'b0;
            while (busy) begin
                cyc++;
                if (cyc == 3) begin
                    bus_we = 1'b1; bus_addr = 32'hF200_0000;
                end else if (cyc == 4) begin
                    bus_we = 1'b1; bus_addr = 32'hF600_0000; bus_wdata = 32'h0000_0100;
                end else begin
                    bus_we = 1'b0;
                end
                @(negedge clk);
            end
            bus_we = 1'b0;
            @(negedge clk);
            @(negedge clk);
            check("R11 busy cycles", cyc, 65);
            check("R11 write during busy ignored", err_cnt, 0);
            check("R10 control register after scan", mmucr, m_cr);
        end
        // R11 the held-off indexed write did not land: entry 0 is still empty
        do_write(32'hF600_0000, 32'h0000_0000);
        check("R11 held-off write left entry empty", inv_cnt, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule